// File: doc/BRIEF.md
# Block-Scaled FP4 to FP32 Expander

This unit turns a stream of packed 4-bit floating-point elements into single-precision values, one value per clock. Elements are grouped in blocks of 32. Each block begins with one 8-bit scale that holds only an exponent. That scale is applied to every element of its block by adding it to the element's exponent, so the datapath has no multiplier.

Input arrives as 32-bit words. A word carries eight elements. The first word of a block is flagged as the start beat, and that beat also carries the scale byte. Three more words complete the block.

Output is a valid/ready stream. It carries the FP32 value and the element's position inside its block. Zeros, a not-a-number scale, exponent overflow and exponent underflow each produce a fixed result. A start beat that arrives while a block is still missing words raises a one-cycle error flag, and sequencing restarts from that beat.

Top module: `mxfp4_block_dequant`

## Requirements
- R1: A beat with `in_start` high opens a block, latches `in_scale` and provides element positions 0..7. The next three beats accepted without `in_start` provide positions 8..15, 16..23 and 24..31. Outputs leave in position order on `out_index`.
- R2: Inside a word, the element in bits [3:0] is emitted first and the element in bits [31:28] last. Word k of a block yields positions 8k to 8k+7.
- R3: An element code is a sign bit in bit 3, a 2-bit exponent field in bits 2:1 and one mantissa bit in bit 0. Codes 0..7 have magnitudes 0, 0.5, 1, 1.5, 2, 3, 4 and 6. A nonzero result is FP32 with the element's sign, a biased exponent equal to the element's unbiased exponent plus the scale byte, the mantissa bit in output bit 22, and bits 21:0 zero.
- R4: The output equals the element magnitude times 2^(scale − 127) for every scale byte from 0 to 254, unless R5, R7 or R8 applies.
- R5: Codes 0x0 and 0x8 give 0x00000000 and 0x80000000 for every scale byte other than 0xFF.
- R6: A scale byte of 0xFF gives 0x7FC00000 for all 32 elements of that block, whatever their codes.
- R7: When the summed biased exponent is 255 or larger, the output is infinity with the element's sign (0x7F800000 or 0xFF800000).
- R8: When the summed biased exponent is 0 or smaller, the output is zero with the element's sign.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_index` hold their values. Under any pattern of `out_ready`, no value is lost or repeated.
- R10: If a start beat is accepted while the open block still expects words, `err_restart` is high for exactly the next cycle. Words accepted before that beat are still emitted, and the new block is then emitted from position 0 with the new scale. A start beat accepted when no block is open leaves `err_restart` low.
- R11: A beat accepted without `in_start` while no block is open produces no output.
- R12: During reset and in the first cycle after it, `out_valid` and `err_restart` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Unit accepts the beat this cycle |
| in_start | input | 1 | Beat opens a new block |
| in_scale | input | 8 | Shared exponent byte, sampled on start beats |
| in_word | input | 32 | Eight packed 4-bit elements |
| out_valid | output | 1 | Output value present |
| out_ready | input | 1 | Consumer takes the value this cycle |
| out_data | output | 32 | FP32 result |
| out_index | output | 5 | Position of the element inside its block |
| err_restart | output | 1 | One-cycle pulse on a start beat inside an open block |

## Verification
The assertions rely on two conditions for the input side. The producer keeps `in_start`, `in_scale` and `in_word` unchanged until `in_ready` accepts the beat. The index property also relies on the fact that a new block or a restart always begins at position 0. The stimulus presents every beat with fixed payload until it is accepted, and only drops `in_valid` after the accepting edge. Random stalls are applied only to `out_ready`. Restart and stray-beat cases are created on purpose in dedicated phases, so the reference model always knows which words will be emitted.

// File: rtl/mxfp4_pkg.sv
package mxfp4_pkg;
  localparam int unsigned ELEM_W     = 4;
  localparam int unsigned SCALE_W    = 8;
  localparam int unsigned FP_W       = 32;
  localparam logic [SCALE_W-1:0] SCALE_NAN = 8'hFF;
  localparam logic [FP_W-1:0]    FP_QNAN   = 32'h7FC0_0000;
  localparam logic [7:0]         FP_EXP_MAX = 8'hFF;
endpackage

// File: rtl/mxfp4_elem_decode.sv
module mxfp4_elem_decode
  import mxfp4_pkg::*;
(
  input  logic [ELEM_W-1:0]  code,
  input  logic [SCALE_W-1:0] scale,
  output logic [FP_W-1:0]    fp
);
  logic              sgn;
  logic [1:0]        efld;
  logic              mbit;
  logic [1:0]        ue_plus1;
  logic              frac;
  logic signed [9:0] biased;

  // Subnormal code 0.5 is rewritten as 1.0 x 2^-1; normals keep their mantissa bit.
  always_comb begin
    sgn      = code[3];
    efld     = code[2:1];
    mbit     = code[0];
    ue_plus1 = efld;
    frac     = (efld == 2'd0) ? 1'b0 : mbit;
    biased   = $signed({2'b00, scale}) + $signed({8'b0, ue_plus1}) - 10'sd1;
  end

  always_comb begin
    if (scale == SCALE_NAN)
      fp = FP_QNAN;
    else if (code[2:0] == 3'd0)
      fp = {sgn, 31'b0};
    else if (biased >= 10'sd255)
      fp = {sgn, FP_EXP_MAX, 23'b0};
    else if (biased <= 10'sd0)
      fp = {sgn, 31'b0};
    else
      fp = {sgn, biased[7:0], frac, 22'b0};
  end
endmodule

// File: rtl/mxfp4_word_unpack.sv
module mxfp4_word_unpack
  import mxfp4_pkg::*;
#(
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned BLOCK_EL = 32,
  localparam int unsigned EPW     = WORD_W / ELEM_W,
  localparam int unsigned WPB     = BLOCK_EL / EPW,
  localparam int unsigned NIB_W   = (EPW > 1) ? $clog2(EPW) : 1,
  localparam int unsigned WPOS_W  = (WPB > 1) ? $clog2(WPB) : 1
)(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic                      in_start,
  input  logic [SCALE_W-1:0]        in_scale,
  input  logic [WORD_W-1:0]         in_word,
  input  logic                      adv,
  output logic                      cur_valid,
  output logic [ELEM_W-1:0]         cur_code,
  output logic [SCALE_W-1:0]        cur_scale,
  output logic [WPOS_W+NIB_W-1:0]   cur_index,
  output logic                      err_restart
);
  logic [WORD_W-1:0]  word_q;
  logic [SCALE_W-1:0] scale_q;
  logic [WPOS_W-1:0]  wpos_q;
  logic [WPOS_W-1:0]  expect_q;
  logic [NIB_W-1:0]   nib_q;
  logic               full_q;
  logic               open_q;
  logic               err_q;
  logic               last_nib;
  logic               acc;
  logic               load;

  assign last_nib    = (nib_q == NIB_W'(EPW - 1));
  assign in_ready    = !full_q || (adv && last_nib);
  assign acc         = in_valid && in_ready;
  assign load        = acc && (in_start || open_q);
  assign cur_valid   = full_q;
  assign cur_code    = word_q[nib_q*ELEM_W +: ELEM_W];
  assign cur_scale   = scale_q;
  assign cur_index   = {wpos_q, nib_q};
  assign err_restart = err_q;

  // Block sequencer: tracks which word position the next accepted beat fills.
  always_ff @(posedge clk) begin
    if (rst) begin
      open_q   <= 1'b0;
      expect_q <= '0;
      wpos_q   <= '0;
      scale_q  <= '0;
      err_q    <= 1'b0;
    end else begin
      err_q <= acc && in_start && open_q;
      if (acc) begin
        if (in_start) begin
          scale_q  <= in_scale;
          wpos_q   <= '0;
          expect_q <= WPOS_W'(1);
          open_q   <= (WPB > 1);
        end else if (open_q) begin
          wpos_q   <= expect_q;
          expect_q <= expect_q + WPOS_W'(1);
          open_q   <= (expect_q != WPOS_W'(WPB - 1));
        end
      end
    end
  end

  // Word holding register and element pointer.
  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      nib_q  <= '0;
      word_q <= '0;
    end else if (load) begin
      word_q <= in_word;
      full_q <= 1'b1;
      nib_q  <= '0;
    end else if (adv) begin
      if (last_nib)
        full_q <= 1'b0;
      else
        nib_q <= nib_q + NIB_W'(1);
    end
  end
endmodule

// File: rtl/mxfp4_block_dequant.sv
module mxfp4_block_dequant
  import mxfp4_pkg::*;
#(
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned BLOCK_EL = 32,
  localparam int unsigned EPW     = WORD_W / ELEM_W,
  localparam int unsigned WPB     = BLOCK_EL / EPW,
  localparam int unsigned NIB_W   = (EPW > 1) ? $clog2(EPW) : 1,
  localparam int unsigned WPOS_W  = (WPB > 1) ? $clog2(WPB) : 1,
  localparam int unsigned IDX_W   = WPOS_W + NIB_W
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_start,
  input  logic [SCALE_W-1:0] in_scale,
  input  logic [WORD_W-1:0]  in_word,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [FP_W-1:0]    out_data,
  output logic [IDX_W-1:0]   out_index,
  output logic               err_restart
);
  logic               cur_valid;
  logic [ELEM_W-1:0]  cur_code;
  logic [SCALE_W-1:0] cur_scale;
  logic [IDX_W-1:0]   cur_index;
  logic [FP_W-1:0]    cur_fp;
  logic               slot_free;
  logic               adv;
  logic               ov_q;
  logic [FP_W-1:0]    od_q;
  logic [IDX_W-1:0]   oi_q;

  assign slot_free = !ov_q || out_ready;
  assign adv       = cur_valid && slot_free;

  mxfp4_word_unpack #(
    .WORD_W   (WORD_W),
    .BLOCK_EL (BLOCK_EL)
  ) u_unpack (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_start    (in_start),
    .in_scale    (in_scale),
    .in_word     (in_word),
    .adv         (adv),
    .cur_valid   (cur_valid),
    .cur_code    (cur_code),
    .cur_scale   (cur_scale),
    .cur_index   (cur_index),
    .err_restart (err_restart)
  );

  mxfp4_elem_decode u_dec (
    .code  (cur_code),
    .scale (cur_scale),
    .fp    (cur_fp)
  );

  // Registered output slot.
  always_ff @(posedge clk) begin
    if (rst) begin
      ov_q <= 1'b0;
      od_q <= '0;
      oi_q <= '0;
    end else if (slot_free) begin
      ov_q <= cur_valid;
      if (adv) begin
        od_q <= cur_fp;
        oi_q <= cur_index;
      end
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign out_index = oi_q;
endmodule

// File: rtl/mxfp4_block_dequant_chk.sv
module mxfp4_block_dequant_chk #(
  parameter int unsigned IDX_W = 5
)(
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_start,
  input logic             out_valid,
  input logic             out_ready,
  input logic [31:0]      out_data,
  input logic [IDX_W-1:0] out_index,
  input logic             err_restart
);
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_index)));

  p_err_cause_r10: assert property (@(posedge clk) disable iff (rst)
    err_restart |-> $past(in_valid && in_ready && in_start));

  p_order_r1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=>
      (!out_valid || out_index == IDX_W'($past(out_index) + 1'b1) || out_index == '0));

  p_special_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_data[30:23] == 8'hFF) |->
      (out_data[22:0] == 23'd0 || out_data == 32'h7FC0_0000));

  p_mant_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_data[30:23] != 8'h00 && out_data[30:23] != 8'hFF) |->
      (out_data[21:0] == 22'd0));

  p_flush_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_data[30:23] == 8'h00) |-> (out_data[22:0] == 23'd0));

  p_reset_r12: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !err_restart && in_ready));
endmodule

bind mxfp4_block_dequant mxfp4_block_dequant_chk #(.IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_start    (in_start),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .out_index   (out_index),
  .err_restart (err_restart)
);

// File: tb/sim_mxfp4_block_dequant.sv
module sim_mxfp4_block_dequant;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_start = 1'b0;
  logic [7:0]  in_scale = '0;
  logic [31:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic [4:0]  out_index;
  logic        err_restart;

  always #10 clk = ~clk;

  mxfp4_block_dequant u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_start(in_start), .in_scale(in_scale), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_index(out_index), .err_restart(err_restart)
  );

  int    checks = 0;
  int    errors = 0;
  int    seen   = 0;
  bit    bp     = 0;
  string phase  = "R4";
  logic [36:0] exp_q[$];
  string       tag_q[$];

  bit model_open = 0;
  int model_pos  = 0;
  int model_scale = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
    end
  endtask

  function automatic logic [31:0] ref_fp(input logic [3:0] code, input int scale);
    int twice, p, e;
    bit mb;
    case (code[2:0])
      3'd0: twice = 0;  3'd1: twice = 1;  3'd2: twice = 2;  3'd3: twice = 3;
      3'd4: twice = 4;  3'd5: twice = 6;  3'd6: twice = 8;  default: twice = 12;
    endcase
    if (scale == 255) return 32'h7FC0_0000;
    if (twice == 0) return {code[3], 31'b0};
    p = 0;
    while ((1 << (p + 1)) <= twice) p++;
    mb = (twice != (1 << p));
    e = (p - 1) + scale;
    if (e >= 255) return {code[3], 8'hFF, 23'b0};
    if (e <= 0) return {code[3], 31'b0};
    return {code[3], e[7:0], mb, 22'b0};
  endfunction

  function automatic string tag_of(input logic [3:0] code, input int scale);
    logic [31:0] v;
    v = ref_fp(code, scale);
    if (scale == 255) return "R6";
    if (code[2:0] == 3'd0) return "R5";
    if (v[30:23] == 8'hFF) return "R7";
    if (v[30:23] == 8'h00) return "R8";
    return phase;
  endfunction

  task automatic push_word(input int pos, input logic [31:0] w, input int scale);
    for (int i = 0; i < 8; i++) begin
      exp_q.push_back({5'(pos * 8 + i), ref_fp(w[i*4 +: 4], scale)});
      tag_q.push_back(tag_of(w[i*4 +: 4], scale));
    end
  endtask

  task automatic beat(input bit st, input int scale, input logic [31:0] w);
    bit exp_err, acc;
    exp_err = 0;
    if (st) begin
      exp_err = model_open;
      model_open = 1; model_pos = 0; model_scale = scale;
      push_word(0, w, scale);
    end else if (model_open) begin
      model_pos++;
      push_word(model_pos, w, model_scale);
      if (model_pos == 3) model_open = 0;
    end
    @(negedge clk);
    in_valid = 1'b1; in_start = st; in_scale = 8'(scale); in_word = w;
    do begin
      #2 acc = in_ready;
      @(posedge clk);
      if (!acc) @(negedge clk);
    end while (!acc);
    #1 in_valid = 1'b0; in_start = 1'b0;
    @(negedge clk);
    #3 chk(err_restart == exp_err, "R10", {31'b0, err_restart}, {31'b0, exp_err});
  endtask

  task automatic block(input int scale, input logic [31:0] w0, w1, w2, w3);
    beat(1, scale, w0); beat(0, scale, w1); beat(0, scale, w2); beat(0, scale, w3);
  endtask

  // Output monitor: drives out_ready, compares every transfer with the model queue.
  initial begin
    logic [36:0] e;
    string t;
    forever begin
      @(negedge clk);
      out_ready = bp ? (($urandom % 3) != 0) : 1'b1;
      #1;
      if (!rst && out_valid && out_ready) begin
        seen++;
        if (exp_q.size() == 0) begin
          chk(0, "R11", out_data, 32'h0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(out_data == e[31:0], t, out_data, e[31:0]);
          chk(out_index == e[36:32], "R1", {27'b0, out_index}, {27'b0, e[36:32]});
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired R1 actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R12", {31'b0, out_valid}, 32'h0);
    chk(err_restart == 1'b0, "R12", {31'b0, err_restart}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    #3 chk(in_ready == 1'b1, "R12", {31'b0, in_ready}, 32'h1);
    chk(out_valid == 1'b0, "R12", {31'b0, out_valid}, 32'h0);

    // R11: words with no open block are dropped
    beat(0, 100, 32'h1234_5678);
    beat(0, 3, 32'hFFFF_FFFF);
    repeat (20) @(negedge clk);
    chk(seen == 0, "R11", 32'(seen), 32'h0);

    // R4 sweep over every scale byte, every code in each block
    phase = "R4";
    for (int s = 0; s < 256; s++)
      block(s, 32'h7654_3210, 32'hFEDC_BA98, 32'h0F1E_2D3C, 32'h8796_A5B4);

    // R2 distinct packings
    phase = "R2";
    block(127, 32'h1357_2468, 32'h0000_000F, 32'hF000_0000, 32'h7777_1111);
    block(130, 32'h0123_4567, 32'h89AB_CDEF, 32'h5A5A_A5A5, 32'h0070_0800);

    // R3 scale 127: element values as-is
    phase = "R3";
    block(127, 32'h7654_3210, 32'hFEDC_BA98, 32'h3333_9999, 32'h1111_EEEE);

    // R9 random backpressure
    phase = "R9";
    bp = 1;
    for (int b = 0; b < 40; b++)
      block(100 + ($urandom % 50), $urandom, $urandom, $urandom, $urandom);
    wait (exp_q.size() == 0);
    repeat (4) @(negedge clk);
    bp = 0;

    // R10 restart inside an open block
    phase = "R10";
    beat(1, 127, 32'h2222_1111);
    beat(0, 127, 32'h4444_3333);
    beat(1, 129, 32'h6666_5555);
    beat(0, 129, 32'h7777_7777);
    beat(0, 129, 32'hAAAA_AAAA);
    beat(0, 129, 32'hCCCC_CCCC);
    beat(1, 120, 32'h1234_5678);
    beat(1, 121, 32'h8765_4321);
    beat(0, 121, 32'h1111_1111);
    beat(0, 121, 32'h2222_2222);
    beat(0, 121, 32'h3333_3333);

    wait (exp_q.size() == 0);
    repeat (10) @(negedge clk);
    chk(out_valid == 1'b0, "R11", {31'b0, out_valid}, 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule